// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit count that only ever moves upward. It advances once for every 1, 4, 8 or 16 system clocks, depending on the prescale setting. Input-capture channels watch synchronized input pins and copy the count on a chosen edge. Output-compare channels raise a flag and can act on an output pin when the count reaches a programmed value. One extra channel works either as a fifth compare or as a fourth capture, selected by a mode bit. Each event source has a status flag that is cleared by writing a 1 to it, and a mask bit that routes that flag to its own interrupt line.

Software reaches the block through a simple word-addressed register port. Reads are registered and return data one cycle after the read strobe, together with a valid pulse. The count can be read but never written. Addresses: 0 count, 1 control, 2 capture edge setup, 3 compare action setup, 4 flags, 5 masks, 16-19 compare values, 20 shared channel value, 21-23 capture values.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the count, the flags, the masks, all setup fields, all pins driven by the block and every interrupt line are 0, and `bus_rvalid` is low.
- R2: A write to the count address (0) has no effect. A read of address 0 returns the count as it stood on the clock edge that sampled the read strobe.
- R3: Control bits [1:0] choose the advance rate: 0, 1, 2 and 3 select one step per 1, 4, 8 and 16 clocks. A free 4-bit cycle counter, cleared by reset, sets the phase: the count steps on every clock edge where that counter's low 0, 2, 3 or 4 bits are all ones.
- R4: Flag bit 8 sets on the edge where the count steps from FFFF to 0000.
- R5: Writing address 4 clears exactly the flag bits written as 1; bits written as 0 keep their value. A new event in the same cycle as a clear leaves the flag set.
- R6: Interrupt line i is high while flag bit i and mask bit i (address 5) are both 1.
- R7: Capture channel c (flag bit 5+c, value at address 21+c) passes its pin through a 2-flop synchronizer. A pin change driven before edge E is captured on edge E+2, and the value copied is the count held just before E+2. The edge setup field [2c+1:2c] selects 0 off, 1 rising, 2 falling, 3 both.
- R8: Compare channel k (value at address 16+k) sets flag bit k on the edge where the count steps to that value.
- R9: On that same edge, compare pin k acts according to setup field [2k+1:2k] of address 3: 0 none, 1 toggle, 2 drive low, 3 drive high.
- R10: Control bit 2 puts the shared channel (flag bit 4, value at address 20) into capture mode. In that mode it captures from `shared_pin_in` according to edge field [7:6], ignores bus writes to address 20, and leaves `shared_pin_out` unchanged. With the bit at 0 it compares against address 20 and drives `shared_pin_out` according to action field [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 5 | register word address |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | registered read data |
| bus_rvalid | output | 1 | read data valid, one cycle after the strobe |
| cap_pin | input | 3 | capture channel input pins |
| shared_pin_in | input | 1 | shared channel input pin (capture mode) |
| cmp_pin | output | 4 | compare channel output pins |
| shared_pin_out | output | 1 | shared channel output pin (compare mode) |
| irq | output | 9 | per-source interrupt lines, same bit order as the flags |

## Verification
Read data arrives one clock after the strobe. The scoreboard records the expected word at the moment it drives the strobe, using a bench model of the count. Capture values and flags become visible on the third edge after the driven pin change, so the bench waits two falling edges and then records the model count. Compare flags and pins change on the edge where the count reaches the programmed value, so the bench checks the pin just before that edge and again just after it. Interrupt lines follow flag and mask registers with no added delay, so they are checked on the falling edge after the write that sets the mask.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } cmp_act_e;

  localparam int A_COUNT = 0;
  localparam int A_CTRL  = 1;
  localparam int A_EDGE  = 2;
  localparam int A_ACT   = 3;
  localparam int A_FLAG  = 4;
  localparam int A_MASK  = 5;
  localparam int A_CMP0  = 16;

endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       div_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick,
  output logic             wrap
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_msk;

  always_comb begin
    case (div_sel)
      2'd0:    pre_msk = '0;
      2'd1:    pre_msk = PRE_W'(3);
      2'd2:    pre_msk = PRE_W'(7);
      default: pre_msk = PRE_W'(15);
    endcase
  end

  assign tick    = (pre_q & pre_msk) == pre_msk;
  assign cnt_nxt = cnt + 1'b1;
  assign wrap    = tick && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pin,
  input  logic [1:0]       edge_cfg,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             hit,
  output logic [CNT_W-1:0] val
);
  logic s1, s2, s3;
  logic rise, fall;

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    case (edge_sel_e'(edge_cfg))
      EDGE_RISE: hit = en && rise;
      EDGE_FALL: hit = en && fall;
      EDGE_ANY:  hit = en && (rise || fall);
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      s3  <= 1'b0;
      val <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
      if (hit)     val <= cnt;
      else if (ld) val <= ld_val;
    end
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] ref_val,
  input  logic [1:0]       act,
  output logic             hit,
  output logic             pin_q
);
  assign hit = en && tick && (cnt_nxt == ref_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (hit) begin
      case (cmp_act_e'(act))
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CMP  = 4,
  parameter int N_CAP  = 3,
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [CNT_W-1:0]             bus_wdata,
  output logic [CNT_W-1:0]             bus_rdata,
  output logic                         bus_rvalid,
  input  logic [N_CAP-1:0]             cap_pin,
  input  logic                         shared_pin_in,
  output logic [N_CMP-1:0]             cmp_pin,
  output logic                         shared_pin_out,
  output logic [N_CMP+N_CAP+1:0]       irq
);
  localparam int NSRC   = N_CMP + N_CAP + 2;
  localparam int EDGE_W = 2 * (N_CAP + 1);
  localparam int ACT_W  = 2 * (N_CMP + 1);
  localparam int A_SHR  = A_CMP0 + N_CMP;
  localparam int A_CAP0 = A_SHR + 1;

  logic [2:0]        ctrl_q;
  logic [EDGE_W-1:0] edge_q;
  logic [ACT_W-1:0]  act_q;
  logic [NSRC-1:0]   flag_q;
  logic [NSRC-1:0]   mask_q;
  logic [CNT_W-1:0]  cmp_q [N_CMP];
  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [CNT_W-1:0]  shr_val;

  logic [1:0]        div_sel;
  logic              shr_cap;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              tick, wrap;
  logic [N_CMP-1:0]  cmp_hit;
  logic [N_CAP-1:0]  cap_hit;
  logic              shr_cmp_hit, shr_cap_hit, shr_wr;
  logic [NSRC-1:0]   set_v, clr_v;
  logic [CNT_W-1:0]  rd_mux;

  assign div_sel = ctrl_q[1:0];
  assign shr_cap = ctrl_q[2];

  tmr_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .div_sel(div_sel),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .tick(tick), .wrap(wrap)
  );

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .en(1'b1), .tick(tick), .cnt_nxt(cnt_nxt),
      .ref_val(cmp_q[k]), .act(act_q[2*k +: 2]),
      .hit(cmp_hit[k]), .pin_q(cmp_pin[k])
    );
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    tmr_cap_chan #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst(rst), .en(1'b1), .pin(cap_pin[c]),
      .edge_cfg(edge_q[2*c +: 2]), .cnt(cnt),
      .ld(1'b0), .ld_val('0), .hit(cap_hit[c]), .val(cap_val[c])
    );
  end

  assign shr_wr = bus_wr && (bus_addr == ADDR_W'(A_SHR)) && !shr_cap;

  tmr_cmp_chan #(.CNT_W(CNT_W)) u_shr_cmp (
    .clk(clk), .rst(rst), .en(!shr_cap), .tick(tick), .cnt_nxt(cnt_nxt),
    .ref_val(shr_val), .act(act_q[2*N_CMP +: 2]),
    .hit(shr_cmp_hit), .pin_q(shared_pin_out)
  );

  tmr_cap_chan #(.CNT_W(CNT_W)) u_shr_cap (
    .clk(clk), .rst(rst), .en(shr_cap), .pin(shared_pin_in),
    .edge_cfg(edge_q[2*N_CAP +: 2]), .cnt(cnt),
    .ld(shr_wr), .ld_val(bus_wdata), .hit(shr_cap_hit), .val(shr_val)
  );

  assign set_v = {wrap, cap_hit, shr_cmp_hit | shr_cap_hit, cmp_hit};
  assign clr_v = (bus_wr && bus_addr == ADDR_W'(A_FLAG)) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      edge_q <= '0;
      act_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
      for (int k = 0; k < N_CMP; k++) cmp_q[k] <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      if (bus_wr) begin
        if (bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[2:0];
        if (bus_addr == ADDR_W'(A_EDGE)) edge_q <= bus_wdata[EDGE_W-1:0];
        if (bus_addr == ADDR_W'(A_ACT))  act_q  <= bus_wdata[ACT_W-1:0];
        if (bus_addr == ADDR_W'(A_MASK)) mask_q <= bus_wdata[NSRC-1:0];
        for (int k = 0; k < N_CMP; k++)
          if (bus_addr == ADDR_W'(A_CMP0 + k)) cmp_q[k] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_COUNT)) rd_mux = cnt;
    if (bus_addr == ADDR_W'(A_CTRL))  rd_mux = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_EDGE))  rd_mux = CNT_W'(edge_q);
    if (bus_addr == ADDR_W'(A_ACT))   rd_mux = CNT_W'(act_q);
    if (bus_addr == ADDR_W'(A_FLAG))  rd_mux = CNT_W'(flag_q);
    if (bus_addr == ADDR_W'(A_MASK))  rd_mux = CNT_W'(mask_q);
    if (bus_addr == ADDR_W'(A_SHR))   rd_mux = shr_val;
    for (int k = 0; k < N_CMP; k++)
      if (bus_addr == ADDR_W'(A_CMP0 + k)) rd_mux = cmp_q[k];
    for (int c = 0; c < N_CAP; c++)
      if (bus_addr == ADDR_W'(A_CAP0 + c)) rd_mux = cap_val[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = flag_q & mask_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CMP  = 4,
  parameter int N_CAP  = 3,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CNT_W-1:0]         cnt,
  input logic [1:0]               div_sel,
  input logic [N_CMP+N_CAP+1:0]   flags,
  input logic [N_CMP:0]           pins,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [CNT_W-1:0]         bus_wdata,
  input logic [CNT_W-1:0]         cap0
);
  localparam int NSRC = N_CMP + N_CAP + 2;

  logic [NSRC-1:0] clr_req;
  assign clr_req = (bus_wr && bus_addr == ADDR_W'(A_FLAG)) ? bus_wdata[NSRC-1:0] : '0;

  // R3
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(div_sel) == 2'd0) |-> cnt == CNT_W'($past(cnt) + 1));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cnt)) |-> cnt == CNT_W'($past(cnt) + 1));

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) == '1 && cnt == '0) |-> flags[NSRC-1]);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~flags & $past(flags) & ~$past(clr_req)) == '0));

  // R7
  capture_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cap0)) |-> flags[N_CMP+1]);

  // R9
  pin_event_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pins ^ $past(pins)) & ~flags[N_CMP:0]) == '0));
endmodule

bind cap_cmp_timer tmr_chk #(
  .CNT_W(CNT_W), .N_CMP(N_CMP), .N_CAP(N_CAP), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .div_sel(div_sel), .flags(flag_q),
  .pins({shared_pin_out, cmp_pin}), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cap0(cap_val[0])
);

// File: tb/cap_cmp_timer_test.sv
`timescale 1ns/1ps
module cap_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [2:0]  cap_pin = '0;
  logic        shared_pin_in = 1'b0;
  logic [3:0]  cmp_pin;
  logic        shared_pin_out;
  logic [8:0]  irq;

  cap_cmp_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cap_pin(cap_pin), .shared_pin_in(shared_pin_in), .cmp_pin(cmp_pin),
    .shared_pin_out(shared_pin_out), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] q_exp[$];
  logic [15:0] q_msk[$];
  string       q_tag[$];

  // reference count built from the prescale rule
  logic [3:0]  m_pre;
  logic [15:0] m_cnt;
  logic [1:0]  m_sel;

  function automatic logic [3:0] pre_mask(input logic [1:0] s);
    case (s)
      2'd0: return 4'h0;
      2'd1: return 4'h3;
      2'd2: return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_sel <= '0;
    end else begin
      m_pre <= m_pre + 1'b1;
      if ((m_pre & pre_mask(m_sel)) == pre_mask(m_sel)) m_cnt <= m_cnt + 1'b1;
      if (bus_wr && bus_addr == 5'd1) m_sel <= bus_wdata[1:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per returned read word
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (q_exp.size() == 0) begin
        check("read with no expectation", 32'h1, 32'h0);
      end else begin
        logic [15:0] e, mk;
        string t;
        e = q_exp.pop_front(); mk = q_msk.pop_front(); t = q_tag.pop_front();
        check(t, 32'(bus_rdata & mk), 32'(e & mk));
      end
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [15:0] e,
                          input logic [15:0] mk, input string t);
    bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(e); q_msk.push_back(mk); q_tag.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_count(input string t);
    bus_read(5'd0, m_cnt, 16'hFFFF, t);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic done = 1'b0;
  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      check("watchdog", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] t, e0;
    idle(3);
    // R1 reset state
    check("R1 cmp pins", 32'(cmp_pin), 0);
    check("R1 shared pin", 32'(shared_pin_out), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 rvalid", 32'(bus_rvalid), 0);
    rst = 1'b0;
    idle(1);
    bus_read(5'd4, 16'h0000, 16'hFFFF, "R1 flags");
    bus_read(5'd2, 16'h0000, 16'hFFFF, "R1 edge setup");
    read_count("R2 count after reset");

    // R2 writes to the count are ignored
    bus_write(5'd0, 16'h1234);
    read_count("R2 count after write");
    read_count("R2 count consecutive");

    // R3 prescale settings
    bus_write(5'd1, 16'h0002);
    idle(21);
    read_count("R3 divide by 8");
    bus_write(5'd1, 16'h0003);
    idle(37);
    read_count("R3 divide by 16");
    bus_write(5'd1, 16'h0001);
    idle(13);
    read_count("R3 divide by 4");
    bus_write(5'd1, 16'h0000);
    idle(2);
    read_count("R3 divide by 1");

    // R8 R9 compare channels 0 (drive high) and 1 (toggle)
    bus_write(5'd3, 16'h0007);
    t = m_cnt + 16'd40;
    bus_write(5'd16, t);
    bus_write(5'd17, t + 16'd5);
    wait_cnt(t - 16'd1);
    check("R9 pin0 before match", 32'(cmp_pin[0]), 0);
    @(negedge clk);
    check("R9 pin0 driven high on match", 32'(cmp_pin[0]), 1);
    bus_read(5'd4, 16'h0001, 16'hFFFF, "R8 compare flag");
    wait_cnt(t + 16'd5);
    check("R9 pin1 toggled", 32'(cmp_pin[1]), 1);

    // R6 interrupt routing
    bus_write(5'd5, 16'h0001);
    check("R6 irq0 with mask", 32'(irq[0]), 1);
    check("R6 irq1 masked", 32'(irq[1]), 0);

    // R5 write-one-to-clear
    bus_write(5'd4, 16'h0000);
    bus_read(5'd4, 16'h0003, 16'hFFFF, "R5 zero write keeps");
    bus_write(5'd4, 16'h0001);
    bus_read(5'd4, 16'h0002, 16'hFFFF, "R5 one write clears");
    check("R5 irq0 after clear", 32'(irq[0]), 0);
    bus_write(5'd4, 16'h01FF);

    // R7 capture: ch0 rising, ch1 falling, ch2 off
    bus_write(5'd2, 16'h0009);
    cap_pin[0] = 1'b1;
    idle(2);
    e0 = m_cnt;
    idle(2);
    bus_read(5'd21, e0, 16'hFFFF, "R7 rising capture");
    bus_read(5'd4, 16'h0020, 16'hFFFF, "R7 capture flag");
    cap_pin[1] = 1'b1;
    idle(5);
    bus_read(5'd22, 16'h0000, 16'hFFFF, "R7 rising ignored on falling ch");
    cap_pin[1] = 1'b0;
    idle(2);
    e0 = m_cnt;
    idle(2);
    bus_read(5'd22, e0, 16'hFFFF, "R7 falling capture");
    cap_pin[2] = 1'b1;
    idle(4);
    cap_pin[2] = 1'b0;
    idle(4);
    bus_read(5'd23, 16'h0000, 16'hFFFF, "R7 disabled channel value");
    bus_read(5'd4, 16'h0060, 16'hFFFF, "R7 disabled channel flag");
    bus_write(5'd4, 16'h01FF);

    // R10 shared channel in capture mode, both edges
    bus_write(5'd1, 16'h0004);
    bus_write(5'd2, 16'h00C9);
    bus_write(5'd20, 16'h5555);
    bus_read(5'd20, 16'h0000, 16'hFFFF, "R10 write ignored in capture mode");
    shared_pin_in = 1'b1;
    idle(2);
    e0 = m_cnt;
    idle(2);
    bus_read(5'd20, e0, 16'hFFFF, "R10 shared capture rising");
    bus_read(5'd4, 16'h0010, 16'hFFFF, "R10 shared flag");
    shared_pin_in = 1'b0;
    idle(2);
    e0 = m_cnt;
    idle(2);
    bus_read(5'd20, e0, 16'hFFFF, "R10 shared capture falling");
    check("R10 shared pin idle in capture mode", 32'(shared_pin_out), 0);

    // R10 shared channel in compare mode
    bus_write(5'd1, 16'h0000);
    bus_write(5'd3, 16'h0307);
    bus_write(5'd4, 16'h01FF);
    t = m_cnt + 16'd30;
    bus_write(5'd20, t);
    wait_cnt(t - 16'd1);
    check("R10 shared pin before match", 32'(shared_pin_out), 0);
    @(negedge clk);
    check("R10 shared pin high on match", 32'(shared_pin_out), 1);
    bus_read(5'd4, 16'h0010, 16'h0010, "R10 shared compare flag");

    // R4 overflow
    bus_write(5'd5, 16'h0100);
    wait_cnt(16'hFFF0);
    bus_write(5'd4, 16'h01FF);
    wait_cnt(16'hFFFE);
    bus_read(5'd4, 16'h0000, 16'h0100, "R4 no flag before wrap");
    wait_cnt(16'h0000);
    check("R4 R6 overflow irq", 32'(irq[8]), 1);
    bus_read(5'd4, 16'h0100, 16'h0100, "R4 overflow flag");
    idle(4);
    check("scoreboard drained", 32'(q_exp.size()), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule